// File: doc/BRIEF.md
# Banked GPIO Controller with Level Interrupts

This block controls sixteen general purpose pins through a set of 8-bit registers. A bank-select register picks which group of eight pins the other registers reach: pins 7:0 or pins 15:8. For each pin, software sets the direction, an output level, a separate output float control, an interrupt enable and an interrupt polarity. The block drives the pad output and output-enable lines and samples the pad inputs through a two-flop synchronizer. It raises one combined interrupt line.

The interrupt is level-sensitive. It is high while at least one pin meets three conditions: the pin is an input, its interrupt is enabled, and its synchronized value equals its polarity bit. The line drops by itself when no pin meets them, so software writes nothing to clear it.

The register port has a 3-bit address, a write strobe with 8-bit write data, and a read-data output. Read data is registered. It appears one clock after the address is presented.

Top module: `pinbank_gpio`

## Requirements
- R1: Synchronous active-high reset sets these states:
  - every pin is an input (direction reads 0xFF in both banks);
  - output level, float, interrupt enable and polarity read 0;
  - the bank select reads 0;
  - `pad_oe` and `irq` are 0.
- R2: Bit 0 of address 0 selects the bank (0 = pins 7:0, 1 = pins 15:8). Reads and writes at addresses 1 to 5 reach only the selected bank. The other bank keeps its state.
- R3: At address 1 (direction), a 1 bit makes the pin an input and a 0 bit makes it an output. An input pin has its `pad_oe` bit low.
- R4: An output pin whose float bit is 0 has `pad_oe` high. Its `pad_out` bit equals the latched output level written at address 2.
- R5: At address 3 (float), a 1 bit on an output pin holds its `pad_oe` bit low.
- R6: Reading address 2 returns, bit by bit, the synchronized pad value for input pins and the latched output value for output pins.
- R7: Pad inputs pass through two flops before readback and interrupt evaluation. A pad change cannot affect `irq` at the first two rising edges after it. The interrupt register captures it at the third edge.
- R8: `irq` rises when a pin meets all three conditions:
  - it is an input;
  - its enable bit at address 4 is 1;
  - its synchronized value matches its polarity bit at address 5 (0 = active while low, 1 = active while high).
- R9: A pin set as output, or with its enable bit at 0, never contributes to `irq`.
- R10: `irq` returns to 0 with no register access once no pin meets the R8 conditions.
- R11: Addresses 6 and 7 read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, one cycle after address |
| pad_in | input | 16 | Pad input values |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables, 1 = drive |
| irq | output | 1 | Combined level-sensitive interrupt |

## Verification
The bench uses the default configuration: sixteen pins, 8-bit registers and therefore two banks. This keeps a full per-pin sweep short.

For every pin and both polarities, the bench checks three things:
- the synchronizer latency, edge by edge;
- that the interrupt sets at the active level;
- that the interrupt is masked by the output direction and by the enable bit, and clears by itself.

Output sweeps apply arithmetic direction, float and level patterns to each bank in turn. After each step they check both banks on `pad_oe`, `pad_out` and the mixed level readback.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_BANK = 3'd0,
    A_DIR  = 3'd1,
    A_LVL  = 3'd2,
    A_FLT  = 3'd3,
    A_IEN  = 3'd4,
    A_POL  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    // R7
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));
  end
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int REG_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic [REG_W-1:0]    rd_data,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] flt_o,
  output logic [NUM_PINS-1:0] ien_o,
  output logic [NUM_PINS-1:0] pol_o
);
  localparam int BANKS  = NUM_PINS / REG_W;
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  logic [BANK_W-1:0] bank_q;
  logic [REG_W-1:0]  dir_r [BANKS];
  logic [REG_W-1:0]  lvl_r [BANKS];
  logic [REG_W-1:0]  flt_r [BANKS];
  logic [REG_W-1:0]  ien_r [BANKS];
  logic [REG_W-1:0]  pol_r [BANKS];
  reg_addr_e         a;
  logic [REG_W-1:0]  rd_next;

  assign a = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      for (int b = 0; b < BANKS; b++) begin
        dir_r[b] <= '1;
        lvl_r[b] <= '0;
        flt_r[b] <= '0;
        ien_r[b] <= '0;
        pol_r[b] <= '0;
      end
    end else if (wr_en) begin
      if (a == A_BANK) bank_q <= wr_data[BANK_W-1:0];
      for (int b = 0; b < BANKS; b++) begin
        if (bank_q == BANK_W'(b)) begin
          case (a)
            A_DIR:   dir_r[b] <= wr_data;
            A_LVL:   lvl_r[b] <= wr_data;
            A_FLT:   flt_r[b] <= wr_data;
            A_IEN:   ien_r[b] <= wr_data;
            A_POL:   pol_r[b] <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bank_q == BANK_W'(b)) begin
        case (a)
          A_DIR:   rd_next = dir_r[b];
          A_LVL:   rd_next = (dir_r[b] & pin_sync[b*REG_W +: REG_W]) |
                             (~dir_r[b] & lvl_r[b]);
          A_FLT:   rd_next = flt_r[b];
          A_IEN:   rd_next = ien_r[b];
          A_POL:   rd_next = pol_r[b];
          default: rd_next = '0;
        endcase
      end
    end
    if (a == A_BANK) rd_next = REG_W'(bank_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else rd_data <= rd_next;
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_flat
    assign dir_o[g*REG_W +: REG_W] = dir_r[g];
    assign lvl_o[g*REG_W +: REG_W] = lvl_r[g];
    assign flt_o[g*REG_W +: REG_W] = flt_r[g];
    assign ien_o[g*REG_W +: REG_W] = ien_r[g];
    assign pol_o[g*REG_W +: REG_W] = pol_r[g];
  end

  // R1
  reset_dir_chk: assert property (@(posedge clk)
    $past(rst) |-> (&dir_o && ien_o == '0 && flt_o == '0));

  if (BANKS > 1) begin : g_bank_chk
    // R2
    other_bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && bank_q == '0) |=>
        ($stable(dir_r[BANKS-1]) && $stable(lvl_r[BANKS-1]) &&
         $stable(ien_r[BANKS-1]) && $stable(pol_r[BANKS-1])));
  end

  // R11
  unused_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr > ADDR_W'(5)) |=>
      ($stable(dir_o) && $stable(lvl_o) && $stable(flt_o) &&
       $stable(ien_o) && $stable(pol_o) && $stable(bank_q)));
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [NUM_PINS-1:0] ien,
  input  logic [NUM_PINS-1:0] pol,
  output logic                irq
);
  logic [NUM_PINS-1:0] hit;

  assign hit = ien & dir & ~(pin_sync ^ pol);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else irq <= |hit;
  end

  // R9
  masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ((ien & dir) == '0) |=> !irq);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(ien & dir)));

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && hit == '0) |=> !irq);
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  logic [NUM_PINS-1:0] pin_sync, dir, lvl, flt, ien, pol;

  pinbank_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync));

  pinbank_regs #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .pin_sync(pin_sync), .rd_data(rd_data), .dir_o(dir), .lvl_o(lvl),
    .flt_o(flt), .ien_o(ien), .pol_o(pol));

  pinbank_irq #(.NUM_PINS(NUM_PINS)) u_irq (
    .clk(clk), .rst(rst), .pin_sync(pin_sync), .dir(dir), .ien(ien),
    .pol(pol), .irq(irq));

  assign pad_oe  = ~dir & ~flt;
  assign pad_out = lvl;

  // R3 R5
  no_drive_input_chk: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & dir) == '0) && ((pad_oe & flt) == '0));
endmodule

// File: tb/pinbank_gpio_test.sv
`timescale 1ns/1ps
module pinbank_gpio_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;
  logic        irq;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] m_dir [2];
  logic [7:0] m_flt [2];
  logic [7:0] m_lvl [2];

  always #2.5 clk = ~clk;

  pinbank_gpio uut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_oe();
    logic [15:0] r;
    for (int b = 0; b < 2; b++) r[b*8 +: 8] = ~m_dir[b] & ~m_flt[b];
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 16'h0);
    check("R1 irq", irq, 1'b0);
    rd(3'd0, d); check("R1 bank", d, 8'h00);
    for (int b = 0; b < 2; b++) begin
      wr(3'd0, 8'(b));
      rd(3'd1, d); check("R1 dir", d, 8'hFF);
      rd(3'd3, d); check("R1 float", d, 8'h00);
      rd(3'd4, d); check("R1 ien", d, 8'h00);
      rd(3'd5, d); check("R1 pol", d, 8'h00);
      rd(3'd2, d); check("R1 lvl", d, 8'h00);
      m_dir[b] = 8'hFF; m_flt[b] = 8'h00; m_lvl[b] = 8'h00;
    end

    // R2 R3 R4 R5 R6 output and readback sweep
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] dv, fv, lv, pv;
        dv = 8'((k * 37) ^ 8'h5A ^ (b * 8'h11));
        fv = 8'((k * 73) ^ 8'h33);
        lv = 8'((k * 29) + 8'h96);
        pv = 8'((k * 53) ^ 8'hC5);
        wr(3'd0, 8'(b));
        wr(3'd1, dv); wr(3'd3, fv); wr(3'd2, lv);
        m_dir[b] = dv; m_flt[b] = fv; m_lvl[b] = lv;
        pad_in = {pv, ~pv};
        tick(3);
        check("R3 R5 R2 pad_oe", pad_oe, exp_oe());
        check("R4 R2 pad_out", pad_out, {m_lvl[1], m_lvl[0]});
        rd(3'd2, d);
        check("R6 lvl readback", d,
              (dv & pad_in[b*8 +: 8]) | (~dv & lv));
        wr(3'd0, 8'(1 - b));
        rd(3'd1, d); check("R2 other bank dir", d, m_dir[1-b]);
      end
    end

    // R11 unused addresses
    wr(3'd0, 8'd1);
    wr(3'd6, 8'hFF); wr(3'd7, 8'hA5);
    rd(3'd6, d); check("R11 addr6", d, 8'h00);
    rd(3'd7, d); check("R11 addr7", d, 8'h00);
    rd(3'd1, d); check("R11 dir kept", d, m_dir[1]);
    rd(3'd3, d); check("R11 float kept", d, m_flt[1]);
    rd(3'd0, d); check("R11 bank kept", d, 8'h01);

    // R7 R8 R9 R10 per-pin interrupt sweep
    for (int b = 0; b < 2; b++) begin
      wr(3'd0, 8'(b)); wr(3'd1, 8'hFF); wr(3'd4, 8'h00);
      m_dir[b] = 8'hFF;
    end
    for (int p = 0; p < 16; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [7:0] bit1;
        bit1 = 8'(1 << (p % 8));
        wr(3'd0, 8'(p / 8));
        wr(3'd5, pol[0] ? bit1 : 8'h00);
        pad_in = pol[0] ? 16'h0000 : 16'hFFFF;
        wr(3'd4, bit1);
        tick(3);
        check("R8 inactive level", irq, 1'b0);
        pad_in[p] = pol[0];
        tick(2);
        check("R7 sync latency", irq, 1'b0);
        tick(1);
        check("R8 active level", irq, 1'b1);
        wr(3'd1, ~bit1);
        tick(1);
        check("R9 output pin masked", irq, 1'b0);
        wr(3'd1, 8'hFF);
        tick(1);
        check("R8 input again", irq, 1'b1);
        wr(3'd4, 8'h00);
        tick(1);
        check("R9 disabled pin", irq, 1'b0);
        wr(3'd4, bit1);
        tick(1);
        check("R8 re-enabled", irq, 1'b1);
        pad_in[p] = ~pol[0];
        tick(3);
        check("R10 self clear", irq, 1'b0);
        wr(3'd4, 8'h00);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule